// File: doc/BRIEF.md
# ADC Command Buffer with Preemption

This block sits between command queues and an analog-to-digital converter. Two command streams feed it: a normal queue and a high-priority queue. Each command word carries a kind bit (configuration or conversion) and a channel number. The buffer holds at most two commands, a head slot that executes and an input slot behind it. It hands them to the converter in order with a one-cycle start pulse, and it waits for a one-cycle done pulse from the converter before it moves on.

When a conversion is executing and the next command is also a conversion, the buffer drives the next channel number to the multiplexer control port before the current conversion ends. It then starts the next conversion on the cycle after done, so back-to-back conversions run at a fixed period. A configuration command never starts early.

With preemption enabled, a high-priority command aborts the converter. The buffer parks the two slots in a shadow store, waits for the converter's acknowledge, and runs the priority stream. It then replays the parked commands in their original order, including the one that was cut off, before it takes normal commands again.

Top module: `adc_cmd_buffer`

## Requirements
- R1: After reset, `cmd_start`, `abort_req` and `mux_pre` are low and `norm_ready` is high.
- R2: Commands start in the order they were accepted, and `cmd_word` carries the accepted word. Bit CH_W of a command word is 1 for a conversion and 0 for configuration. Bits CH_W-1:0 are the channel.
- R3: A command that follows a configuration command, and a configuration command itself, starts two cycles after the done pulse of the command before it, never one.
- R4: A conversion that follows an executing conversion, and was waiting in the input slot, starts on the cycle right after the done pulse.
- R5: While a conversion executes and a conversion waits behind it, `mux_pre` is high and `mux_ch` shows the waiting conversion's channel before that conversion starts.
- R6: Back-to-back conversions start at an interval of the converter latency plus one cycle.
- R7: With `abort_en` high, a priority command that arrives while a slot is occupied raises `abort_req`. The request is held until `abort_ack`, and no start is issued while it is high.
- R8: `prio_ready` stays low while `abort_req` is high, so the first priority command starts only after the acknowledge.
- R9: After the priority queue empties, the parked commands start again in their original order, and the aborted command runs again from the start.
- R10: No normal command is accepted from the abort until the last parked command has been taken back into the slots.
- R11: A priority command that arrives while parked commands are being replayed waits until the replay completes. The shadow store is never overwritten while it holds commands.
- R12: With `abort_en` low, a waiting priority command is accepted ahead of a waiting normal command, and `abort_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_en | input | 1 | Enables preemption by the priority queue |
| norm_valid | input | 1 | Normal queue has a command |
| norm_ready | output | 1 | Normal command accepted this cycle when valid |
| norm_cmd | input | CH_W+1 | Normal command word |
| prio_valid | input | 1 | Priority queue has a command |
| prio_ready | output | 1 | Priority command accepted this cycle when valid |
| prio_cmd | input | CH_W+1 | Priority command word |
| cmd_start | output | 1 | One-cycle start pulse to the converter |
| cmd_word | output | CH_W+1 | Command being started |
| conv_done | input | 1 | Converter finished the executing command |
| abort_req | output | 1 | Abort request to the converter |
| abort_ack | input | 1 | Converter has aborted |
| mux_pre | output | 1 | Early channel select for the waiting conversion |
| mux_ch | output | CH_W | Channel for the input multiplexer |

## Verification
A slot or mode register that holds the wrong value shows up at the converter port within one command time. Either the next `cmd_start` carries a word out of order or it arrives one cycle too early or too late relative to `conv_done`. A scoreboard checks each start against the accepted order and against the gap to the last done pulse, so a lost pipelining decision or a config command started early fails at that very start. A broken shadow store or mode machine during preemption shows up as a missing, repeated or reordered command after the priority burst, or as a normal command that overtakes the replay.

// File: rtl/acb_pkg.sv
package acb_pkg;
  typedef enum logic [1:0] {M_NORM, M_WAIT, M_PRIO, M_REST} acb_mode_e;
  typedef enum logic [1:0] {S_NONE, S_NORM, S_PRIO, S_SHAD} acb_src_e;
endpackage

// File: rtl/acb_slots.sv
module acb_slots #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            ld_valid,
  input  logic [CH_W:0]   ld_cmd,
  output logic            ld_ready,
  input  logic            done,
  output logic            start,
  output logic [CH_W:0]   start_cmd,
  output logic            mux_pre,
  output logic [CH_W-1:0] mux_ch,
  output logic            h_v,
  output logic [CH_W:0]   h_c,
  output logic            i_v,
  output logic [CH_W:0]   i_c
);
  localparam int KIND = CH_W;

  logic h_busy;
  logic h_conv, i_conv, finish, advance, chain, pair, ld_fire;

  assign h_conv   = h_c[KIND];
  assign i_conv   = i_c[KIND];
  assign finish   = h_v && h_busy && done;
  assign advance  = finish || (!h_v && i_v);
  assign pair     = h_v && h_busy && h_conv && i_v && i_conv;
  assign chain    = finish && pair;
  assign ld_ready = !i_v && !flush;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      h_v       <= 1'b0;
      i_v       <= 1'b0;
      h_busy    <= 1'b0;
      start     <= 1'b0;
      mux_pre   <= 1'b0;
      if (rst) begin
        h_c       <= '0;
        i_c       <= '0;
        start_cmd <= '0;
        mux_ch    <= '0;
      end
    end else begin
      start   <= 1'b0;
      mux_pre <= 1'b0;
      if (advance) begin
        h_v <= i_v;
        h_c <= i_c;
        i_v <= ld_fire;
      end else begin
        i_v <= i_v || ld_fire;
      end
      if (ld_fire) i_c <= ld_cmd;
      if (chain) begin
        h_busy    <= 1'b1;
        start     <= 1'b1;
        start_cmd <= i_c;
      end else if (advance) begin
        h_busy <= 1'b0;
      end else if (h_v && !h_busy) begin
        h_busy    <= 1'b1;
        start     <= 1'b1;
        start_cmd <= h_c;
        if (h_conv) mux_ch <= h_c[CH_W-1:0];
      end
      if (pair) begin
        mux_pre <= 1'b1;
        mux_ch  <= i_c[CH_W-1:0];
      end
    end
  end

  AST_CFG_FROM_HEAD: assert property (@(posedge clk) disable iff (rst)
    (start && !start_cmd[KIND]) |-> !$past(done)); // R3
endmodule

// File: rtl/acb_shadow.sv
module acb_shadow #(
  parameter int CH_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save,
  input  logic          h_v,
  input  logic [CH_W:0] h_c,
  input  logic          i_v,
  input  logic [CH_W:0] i_c,
  input  logic          pop,
  output logic          out_valid,
  output logic [CH_W:0] out_cmd
);
  localparam int DEPTH = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CH_W:0] ent [DEPTH];
  logic [CW-1:0] cnt;
  logic          rd;

  assign out_valid = (cnt != '0);
  assign out_cmd   = ent[rd];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rd  <= 1'b0;
    end else if (save) begin
      rd <= 1'b0;
      if (h_v) begin
        ent[0] <= h_c;
        ent[1] <= i_c;
        cnt    <= i_v ? CW'(2) : CW'(1);
      end else begin
        ent[0] <= i_c;
        cnt    <= i_v ? CW'(1) : CW'(0);
      end
    end else if (pop && out_valid) begin
      rd  <= ~rd;
      cnt <= cnt - CW'(1);
    end
  end

  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (rst)
    save |-> (cnt == '0)); // R11
endmodule

// File: rtl/acb_ctrl.sv
module acb_ctrl
  import acb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     abort_en,
  input  logic     norm_valid,
  input  logic     prio_valid,
  input  logic     sh_valid,
  input  logic     slots_busy,
  input  logic     ld_ready,
  input  logic     abort_ack,
  output acb_src_e src,
  output logic     ld_valid,
  output logic     norm_ready,
  output logic     prio_ready,
  output logic     sh_pop,
  output logic     save,
  output logic     abort_req
);
  acb_mode_e mode;
  logic      trigger;

  assign trigger = (mode == M_NORM) && abort_en && prio_valid;
  assign save    = trigger && slots_busy;

  always_comb begin
    case (mode)
      M_NORM:  src = trigger ? S_NONE : (prio_valid ? S_PRIO : S_NORM);
      M_PRIO:  src = S_PRIO;
      M_REST:  src = S_SHAD;
      default: src = S_NONE;
    endcase
    case (src)
      S_NORM:  ld_valid = norm_valid;
      S_PRIO:  ld_valid = prio_valid;
      S_SHAD:  ld_valid = sh_valid;
      default: ld_valid = 1'b0;
    endcase
  end

  assign norm_ready = (src == S_NORM) && ld_ready;
  assign prio_ready = (src == S_PRIO) && ld_ready;
  assign sh_pop     = (src == S_SHAD) && ld_ready && sh_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_NORM;
      abort_req <= 1'b0;
    end else begin
      case (mode)
        M_NORM: if (trigger) begin
          mode      <= slots_busy ? M_WAIT : M_PRIO;
          abort_req <= slots_busy;
        end
        M_WAIT: if (abort_ack) begin
          mode      <= M_PRIO;
          abort_req <= 1'b0;
        end
        M_PRIO: if (!prio_valid) mode <= sh_valid ? M_REST : M_NORM;
        default: if (!sh_valid) mode <= M_NORM;
      endcase
    end
  end

  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !abort_ack) |=> abort_req); // R7
  AST_PRIO_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> !prio_ready); // R8
  AST_REPLAY_GATES_NORM: assert property (@(posedge clk) disable iff (rst)
    sh_valid |-> !norm_ready); // R10
endmodule

// File: rtl/adc_cmd_buffer.sv
module adc_cmd_buffer
  import acb_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort_en,
  input  logic            norm_valid,
  output logic            norm_ready,
  input  logic [CH_W:0]   norm_cmd,
  input  logic            prio_valid,
  output logic            prio_ready,
  input  logic [CH_W:0]   prio_cmd,
  output logic            cmd_start,
  output logic [CH_W:0]   cmd_word,
  input  logic            conv_done,
  output logic            abort_req,
  input  logic            abort_ack,
  output logic            mux_pre,
  output logic [CH_W-1:0] mux_ch
);
  acb_src_e      src;
  logic          ld_valid, ld_ready, sh_valid, sh_pop, save;
  logic          h_v, i_v;
  logic [CH_W:0] h_c, i_c, sh_cmd, ld_cmd;

  always_comb begin
    case (src)
      S_PRIO:  ld_cmd = prio_cmd;
      S_SHAD:  ld_cmd = sh_cmd;
      default: ld_cmd = norm_cmd;
    endcase
  end

  acb_ctrl u_ctrl (
    .clk, .rst, .abort_en, .norm_valid, .prio_valid,
    .sh_valid, .slots_busy(h_v || i_v), .ld_ready, .abort_ack,
    .src, .ld_valid, .norm_ready, .prio_ready, .sh_pop, .save, .abort_req
  );

  acb_slots #(.CH_W(CH_W)) u_slots (
    .clk, .rst, .flush(save), .ld_valid, .ld_cmd, .ld_ready,
    .done(conv_done), .start(cmd_start), .start_cmd(cmd_word),
    .mux_pre, .mux_ch, .h_v, .h_c, .i_v, .i_c
  );

  acb_shadow #(.CH_W(CH_W)) u_shadow (
    .clk, .rst, .save, .h_v, .h_c, .i_v, .i_c,
    .pop(sh_pop), .out_valid(sh_valid), .out_cmd(sh_cmd)
  );

  AST_QUIET_DURING_ABORT: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> !cmd_start); // R7
endmodule

// File: tb/tb_adc_cmd_buffer.sv
module tb_adc_cmd_buffer;
  localparam int CH_W = 4;
  localparam int LAT  = 6;
  localparam int WD   = 20000;

  logic clk = 1'b0, rst = 1'b1, abort_en = 1'b0;
  logic norm_valid = 1'b0, prio_valid = 1'b0;
  logic [CH_W:0] norm_cmd = '0, prio_cmd = '0;
  logic norm_ready, prio_ready, cmd_start, abort_req, mux_pre;
  logic [CH_W:0] cmd_word;
  logic [CH_W-1:0] mux_ch;
  logic conv_done = 1'b0, abort_ack = 1'b0;

  int checks = 0, fails = 0, cyc = 0, starts = 0;
  int last_done = -100, last_start = -100, cnt = 0, aborts = 0;
  bit busy = 0, pre_seen = 0;
  logic [CH_W-1:0] pre_ch = '0;
  logic [CH_W:0] exp_cmd[$];
  int exp_gap[$];
  string exp_req[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_cmd_buffer #(.CH_W(CH_W)) dut (
    .clk, .rst, .abort_en, .norm_valid, .norm_ready, .norm_cmd,
    .prio_valid, .prio_ready, .prio_cmd, .cmd_start, .cmd_word,
    .conv_done, .abort_req, .abort_ack, .mux_pre, .mux_ch
  );

  function automatic logic [CH_W:0] mk(input bit conv, input int ch);
    return {conv, CH_W'(ch)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expect_cmd(input logic [CH_W:0] c, input int gap, input string req);
    exp_cmd.push_back(c); exp_gap.push_back(gap); exp_req.push_back(req);
  endtask

  // caller is at a negedge; returns just after the accepting posedge
  task automatic feed(input bit prio, input logic [CH_W:0] c);
    bit rdy;
    if (prio) begin prio_valid = 1'b1; prio_cmd = c; end
    else begin norm_valid = 1'b1; norm_cmd = c; end
    forever begin
      #1 rdy = prio ? prio_ready : norm_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1;
    if (prio) prio_valid = 1'b0; else norm_valid = 1'b0;
  endtask

  // scoreboard monitor and converter model
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (!rst) begin
      if (cmd_start) begin
        starts++;
        if (exp_cmd.size() == 0) begin
          chk(1'b0, "R2", int'(cmd_word), -1);
        end else begin
          automatic logic [CH_W:0] e = exp_cmd.pop_front();
          automatic int g = exp_gap.pop_front();
          automatic string r = exp_req.pop_front();
          chk(cmd_word == e, r, int'(cmd_word), int'(e));
          if (g >= 0) chk(cyc - last_done == g, (g == 1) ? "R4" : "R3", cyc - last_done, g);
          if (g == 1) begin
            chk(pre_seen && pre_ch == cmd_word[CH_W-1:0], "R5", int'(pre_ch), int'(cmd_word[CH_W-1:0]));
            chk(cyc - last_start == LAT + 1, "R6", cyc - last_start, LAT + 1);
          end
        end
        pre_seen = 0; last_start = cyc; busy = 1; cnt = LAT;
      end else if (busy) begin
        cnt--;
        if (cnt == 0) begin busy = 0; conv_done = 1'b1; last_done = cyc; end
      end
      if (abort_req) begin
        busy = 0; conv_done = 1'b0; aborts++;
        chk(!cmd_start, "R7", int'(cmd_start), 0);
        chk(!prio_ready, "R8", int'(prio_ready), 0);
        chk(abort_en, "R12", int'(abort_en), 1);
        abort_ack = !abort_ack;
      end else begin
        abort_ack = 1'b0;
      end
      if (mux_pre) begin pre_seen = 1; pre_ch = mux_ch; end
    end
  end

  task automatic drain;
    wait (exp_cmd.size() == 0);
    repeat (LAT + 4) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    chk(1'b0, "watchdog", cyc, WD);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!cmd_start, "R1", int'(cmd_start), 0);
    chk(!abort_req, "R1", int'(abort_req), 0);
    chk(!mux_pre, "R1", int'(mux_pre), 0);
    chk(norm_ready, "R1", int'(norm_ready), 1);
    @(negedge clk);

    // order, pipelining of conversions, config boundary (R2..R6)
    expect_cmd(mk(1, 1), -1, "R2");
    expect_cmd(mk(1, 2), 1, "R4");
    expect_cmd(mk(1, 3), 1, "R4");
    expect_cmd(mk(0, 4), 2, "R3");
    expect_cmd(mk(1, 5), 2, "R3");
    expect_cmd(mk(1, 6), 1, "R6");
    for (int k = 1; k <= 6; k++) begin
      feed(0, mk(k != 4, k));
      @(negedge clk);
    end
    drain();

    // priority precedence without preemption (R12)
    begin
      automatic int base = starts;
      expect_cmd(mk(1, 7), -1, "R2");
      expect_cmd(mk(1, 8), -1, "R2");
      expect_cmd(mk(0, 9), -1, "R12");
      expect_cmd(mk(1, 10), -1, "R12");
      fork
        begin
          for (int k = 7; k <= 8; k++) begin feed(0, mk(1, k)); @(negedge clk); end
          feed(0, mk(1, 10));
        end
        begin
          wait (starts == base + 1);
          feed(1, mk(0, 9));
        end
      join
      @(negedge clk);
      drain();
      chk(aborts == 0, "R12", aborts, 0);
    end

    // preemption, replay, waiting priority (R7..R11)
    abort_en = 1'b1;
    begin
      automatic int base = starts;
      expect_cmd(mk(1, 1), -1, "R2");
      expect_cmd(mk(0, 12), -1, "R8");
      expect_cmd(mk(1, 13), -1, "R8");
      expect_cmd(mk(1, 1), -1, "R9");
      expect_cmd(mk(1, 2), -1, "R9");
      expect_cmd(mk(1, 14), -1, "R11");
      expect_cmd(mk(1, 3), -1, "R10");
      fork
        begin
          for (int k = 1; k <= 2; k++) begin feed(0, mk(1, k)); @(negedge clk); end
          feed(0, mk(1, 3));
        end
        begin
          wait (starts == base + 1);
          feed(1, mk(0, 12));
          @(negedge clk);
          feed(1, mk(1, 13));
          wait (starts == base + 4);
          abort_en = 1'b0;
          prio_valid = 1'b1; prio_cmd = mk(1, 14);
          #1 chk(!prio_ready, "R11", int'(prio_ready), 0);
          feed(1, mk(1, 14));
        end
      join
      @(negedge clk);
      drain();
      chk(aborts == 1, "R7", aborts, 1);
    end
    chk(exp_cmd.size() == 0, "R2", exp_cmd.size(), 0);
    finish_run();
  end
endmodule